// File: doc/BRIEF.md
# Multi-source XOR descriptor executor

This block takes one descriptor at a time and runs it over parallel word streams. The descriptor is a 32-bit control word and a 32-bit byte count. The control word picks one of three operations. An idle operation moves no data. A copy moves words from source lane 0 to the result stream. A parity operation XORs between one and eight source lanes, word by word, into the result stream. Any other operation code is refused.

Every source lane and the result stream use valid/ready handshakes. The result stream is combinational from the active lanes. A result word is offered only when every active lane holds a word, and all active lanes are consumed together on the result handshake.

When a descriptor ends, the block raises a one-cycle completion pulse. The pulse carries the descriptor's interrupt request bit and an error flag. The error flag covers a refused operation code, an out-of-range lane count, and a parity run whose parity output is not enabled. An erroneous descriptor moves no data. The byte count is rounded up to whole bus words, and a zero count finishes at once.

Top module: `xde_desc_exec`

## Requirements
- R1: While reset is held, `desc_ready` is 1, and `dst_valid`, `done_valid` and all `src_ready` bits are 0.
- R2: An operation code (control bits [31:28]) of 0 moves no data. `done_valid` rises in the cycle after the descriptor is accepted, with `done_err` = 0 and `done_irq` equal to control bit 27.
- R3: An operation code other than 0, 1 or 6 moves no data. It completes in the cycle after acceptance with `done_err` = 1 and `done_irq` equal to bit 27.
- R4: For code 6, the active lane count is control bits [25:22]. A count of 0, or a count above 8 or above `NUM_SRC`, moves no data and completes in the cycle after acceptance with `done_err` = 1.
- R5: For code 6, parity output is enabled by bit 17. With bit 17 clear, no data moves and the descriptor completes in the cycle after acceptance with `done_err` = 1. Bit 16 has no effect on any output.
- R6: For code 1, `dst_data` equals the word on lane 0. Only `src_ready[0]` is ever raised.
- R7: For code 6 with count N, lanes 0..N-1 are active. `dst_valid` is 1 exactly when every active lane is valid. `dst_data` is the bitwise XOR of their words. `src_ready` equals the active mask in a cycle with a result handshake and is 0 otherwise.
- R8: A copy or parity run moves ceil(size / (DATA_W/8)) words. `done_valid` rises in the cycle after the last result handshake, with `done_err` = 0 and `done_irq` equal to bit 27.
- R9: A valid copy or parity descriptor whose size is 0 moves no data and completes in the cycle after acceptance with `done_err` = 0.
- R10: `desc_ready` is 1 only when no descriptor is in progress or completing. `done_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can accept a descriptor |
| desc_ctrl | input | 32 | Control word: operation, lane count, flags |
| desc_size | input | 32 | Transfer length in bytes |
| src_valid | input | NUM_SRC | Per-lane word valid |
| src_ready | output | NUM_SRC | Per-lane word consumed |
| src_data | input | NUM_SRC*DATA_W | Lane words, lane i at bits [i*DATA_W +: DATA_W] |
| dst_valid | output | 1 | Result word valid |
| dst_ready | input | 1 | Result word taken |
| dst_data | output | DATA_W | Result word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_irq | output | 1 | Interrupt requested by the finished descriptor |
| done_err | output | 1 | Finished descriptor was refused |

## Verification
The result path has no register. `dst_valid`, `dst_data` and `src_ready` follow the lane inputs and `dst_ready` in the same cycle. The completion pulse comes one register later: in the cycle after acceptance when no data moves, or in the cycle after the final result handshake. `desc_ready` drops in the cycle after acceptance and comes back in the cycle after the pulse. The bench changes inputs only at the falling edge and samples 1 ns later. A behavioural model is advanced by the handshakes it saw in the previous cycle, and every output is compared against that model in every cycle, with the lanes both free-running and randomly stalled.

// File: rtl/xde_pkg.sv
`timescale 1ns/1ps
package xde_pkg;
   // Control word field positions (these are decoded by the block)
   localparam int OP_LSB   = 28;
   localparam int OP_W     = 4;
   localparam int IRQ_BIT  = 27;
   localparam int CNT_LSB  = 22;
   localparam int CNT_W    = 4;
   localparam int PEN_BIT  = 17;
   localparam int MAX_LANE = 8;

   localparam logic [OP_W-1:0] OPC_IDLE   = 4'd0;
   localparam logic [OP_W-1:0] OPC_COPY   = 4'd1;
   localparam logic [OP_W-1:0] OPC_PARITY = 4'd6;

   typedef enum logic [1:0] {
      MODE_NONE   = 2'd0,
      MODE_COPY   = 2'd1,
      MODE_PARITY = 2'd2
   } mode_e;

   typedef struct packed {
      mode_e            mode;
      logic             fault;
      logic             irq;
      logic [CNT_W-1:0] cnt;
   } cmd_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MOVE = 2'd1,
      ST_DONE = 2'd2
   } seq_e;
endpackage

// File: rtl/xde_decode.sv
`timescale 1ns/1ps
module xde_decode
   import xde_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 32,
   parameter int SIZE_W  = 32,
   localparam int BYTES   = DATA_W / 8,
   localparam int BYTE_SH = (BYTES > 1) ? $clog2(BYTES) : 0,
   localparam int WCNT_W  = SIZE_W + 1 - BYTE_SH
) (
   input  logic [31:0]       ctrl,
   input  logic [SIZE_W-1:0] size,
   output cmd_t              cmd,
   output logic [WCNT_W-1:0] words,
   output logic              skip
);
   logic [OP_W-1:0]   opc;
   logic [CNT_W-1:0]  cnt;
   logic              cnt_bad;
   logic [SIZE_W:0]   size_up;
   logic              ctl_unused;

   assign opc = ctrl[OP_LSB +: OP_W];
   assign cnt = ctrl[CNT_LSB +: CNT_W];
   assign cnt_bad = (cnt == '0) || (int'(cnt) > NUM_SRC) || (int'(cnt) > MAX_LANE);
   assign ctl_unused = ^{ctrl[26], ctrl[21:18], ctrl[16:0]};

   always_comb begin
      cmd.irq  = ctrl[IRQ_BIT];
      cmd.cnt  = cnt;
      cmd.mode = MODE_NONE;
      cmd.fault = 1'b0;
      unique case (opc)
         OPC_IDLE:   cmd.mode = MODE_NONE;
         OPC_COPY:   cmd.mode = MODE_COPY;
         OPC_PARITY: begin
            cmd.mode  = MODE_PARITY;
            cmd.fault = cnt_bad || !ctrl[PEN_BIT];
         end
         default:    cmd.fault = 1'b1;
      endcase
   end

   // Round the byte count up to whole bus words
   assign size_up = {1'b0, size} + (SIZE_W+1)'(BYTES - 1);
   assign words   = size_up[SIZE_W:BYTE_SH];
   assign skip    = cmd.fault || (cmd.mode == MODE_NONE) || (words == '0);
endmodule

// File: rtl/xde_lane_join.sv
`timescale 1ns/1ps
module xde_lane_join #(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 32,
   parameter bit TREE    = 1'b1,
   localparam int LV     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0,
   localparam int LEAVES = 1 << LV
) (
   input  logic [NUM_SRC-1:0]        mask,
   input  logic [NUM_SRC-1:0]        src_valid,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   output logic                      all_ok,
   output logic [DATA_W-1:0]         word
);
   logic [DATA_W-1:0] masked [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
      assign masked[i] = src_data[i*DATA_W +: DATA_W] & {DATA_W{mask[i]}};
   end

   assign all_ok = &(src_valid | ~mask);

   if (TREE) begin : g_tree
      logic [DATA_W-1:0] nd [2*LEAVES-1];
      for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
         if (l < NUM_SRC) begin : g_real
            assign nd[LEAVES-1+l] = masked[l];
         end else begin : g_pad
            assign nd[LEAVES-1+l] = '0;
         end
      end
      for (genvar j = 0; j < LEAVES-1; j++) begin : g_node
         assign nd[j] = nd[2*j+1] ^ nd[2*j+2];
      end
      assign word = nd[0];
   end else begin : g_chain
      logic [DATA_W-1:0] acc [NUM_SRC];
      assign acc[0] = masked[0];
      for (genvar i = 1; i < NUM_SRC; i++) begin : g_link
         assign acc[i] = acc[i-1] ^ masked[i];
      end
      assign word = acc[NUM_SRC-1];
   end
endmodule

// File: rtl/xde_seq.sv
`timescale 1ns/1ps
module xde_seq
   import xde_pkg::*;
#(
   parameter int WCNT_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_valid,
   input  cmd_t              cmd,
   input  logic [WCNT_W-1:0] words,
   input  logic              skip,
   input  logic              beat,
   output logic              desc_ready,
   output logic              accept,
   output logic              run,
   output logic              done_valid,
   output logic              done_irq,
   output logic              done_err
);
   seq_e              st;
   logic [WCNT_W-1:0] remain;
   logic              irq_q, err_q;

   assign desc_ready = (st == ST_IDLE);
   assign accept     = desc_valid && desc_ready;
   assign run        = (st == ST_MOVE);
   assign done_valid = (st == ST_DONE);
   assign done_irq   = done_valid && irq_q;
   assign done_err   = done_valid && err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         remain <= '0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (accept) begin
               remain <= words;
               irq_q  <= cmd.irq;
               err_q  <= cmd.fault;
               st     <= skip ? ST_DONE : ST_MOVE;
            end
            ST_MOVE: if (beat) begin
               remain <= remain - WCNT_W'(1);
               if (remain == WCNT_W'(1)) st <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xde_desc_exec.sv
`timescale 1ns/1ps
module xde_desc_exec
   import xde_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 32,
   parameter bit TREE    = 1'b1,
   localparam int SIZE_W  = 32,
   localparam int BYTES   = DATA_W / 8,
   localparam int BYTE_SH = (BYTES > 1) ? $clog2(BYTES) : 0,
   localparam int WCNT_W  = SIZE_W + 1 - BYTE_SH
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      desc_valid,
   output logic                      desc_ready,
   input  logic [31:0]               desc_ctrl,
   input  logic [SIZE_W-1:0]         desc_size,
   input  logic [NUM_SRC-1:0]        src_valid,
   output logic [NUM_SRC-1:0]        src_ready,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   output logic                      dst_valid,
   input  logic                      dst_ready,
   output logic [DATA_W-1:0]         dst_data,
   output logic                      done_valid,
   output logic                      done_irq,
   output logic                      done_err
);
   if (DATA_W < 8 || (DATA_W % 8) != 0 || (1 << BYTE_SH) != BYTES) begin : g_bad_width
      $error("xde_desc_exec: DATA_W must be a power-of-two number of bytes");
   end
   if (NUM_SRC < 1 || NUM_SRC > MAX_LANE) begin : g_bad_lanes
      $error("xde_desc_exec: NUM_SRC must lie in 1..8");
   end

   cmd_t               cmd;
   logic [WCNT_W-1:0]  words;
   logic               skip, accept, run, beat, all_ok;
   logic [NUM_SRC-1:0] mask_d, mask_q;

   xde_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dec (
      .ctrl  (desc_ctrl),
      .size  (desc_size),
      .cmd   (cmd),
      .words (words),
      .skip  (skip)
   );

   always_comb begin
      mask_d = '0;
      if (cmd.mode == MODE_COPY) begin
         mask_d[0] = 1'b1;
      end else if (cmd.mode == MODE_PARITY) begin
         for (int i = 0; i < NUM_SRC; i++) mask_d[i] = (i < int'(cmd.cnt));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (accept) mask_q <= mask_d;
   end

   xde_lane_join #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .TREE(TREE)) u_join (
      .mask      (mask_q),
      .src_valid (src_valid),
      .src_data  (src_data),
      .all_ok    (all_ok),
      .word      (dst_data)
   );

   assign dst_valid = run && all_ok;
   assign beat      = dst_valid && dst_ready;
   assign src_ready = beat ? mask_q : '0;

   xde_seq #(.WCNT_W(WCNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_valid (desc_valid),
      .cmd        (cmd),
      .words      (words),
      .skip       (skip),
      .beat       (beat),
      .desc_ready (desc_ready),
      .accept     (accept),
      .run        (run),
      .done_valid (done_valid),
      .done_irq   (done_irq),
      .done_err   (done_err)
   );
endmodule

// File: rtl/xde_chk.sv
`timescale 1ns/1ps
module xde_chk #(
   parameter int NUM_SRC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               desc_valid,
   input logic               desc_ready,
   input logic [NUM_SRC-1:0] src_valid,
   input logic [NUM_SRC-1:0] src_ready,
   input logic               dst_valid,
   input logic               dst_ready,
   input logic               done_valid
);
   logic rst_seen;

   always_ff @(posedge clk) begin
      rst_seen <= !rst_n;
      if (!rst_n && rst_seen) begin
         p_reset_quiet_r1: assert (!dst_valid && !done_valid && src_ready == '0 && desc_ready)
            else $error("reset state violated");
      end
   end

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_ready) |=> !desc_ready);

   p_done_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !desc_ready);

   p_idle_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ready |-> (!dst_valid && src_ready == '0));

   p_consume_on_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_ready) |-> (dst_valid && dst_ready));

   p_consume_only_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_ready) |-> ((src_ready & ~src_valid) == '0));
endmodule

bind xde_desc_exec xde_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .desc_valid (desc_valid),
   .desc_ready (desc_ready),
   .src_valid  (src_valid),
   .src_ready  (src_ready),
   .dst_valid  (dst_valid),
   .dst_ready  (dst_ready),
   .done_valid (done_valid)
);

// File: tb/tb_xde_desc_exec.sv
`timescale 1ns/1ps
module tb_xde_desc_exec;
   localparam int NS = 8;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              desc_valid = 1'b0;
   logic              desc_ready;
   logic [31:0]       desc_ctrl = '0;
   logic [31:0]       desc_size = '0;
   logic [NS-1:0]     src_valid = '0;
   logic [NS-1:0]     src_ready;
   logic [NS*DW-1:0]  src_data = '0;
   logic              dst_valid;
   logic              dst_ready = 1'b0;
   logic [DW-1:0]     dst_data;
   logic              done_valid, done_irq, done_err;

   always #10 clk = ~clk;

   xde_desc_exec #(.NUM_SRC(NS), .DATA_W(DW), .TREE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_ctrl(desc_ctrl), .desc_size(desc_size),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
      .done_valid(done_valid), .done_irq(done_irq), .done_err(done_err)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit finished = 0;
   bit stall = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [31:0] q_ctrl[$];
   logic [31:0] q_size[$];

   // model: 0 idle, 1 moving, 2 completing
   int          m_st = 0;
   longint      m_rem = 0;
   logic [NS-1:0] m_mask = '0;
   bit          m_irq = 0, m_err = 0;
   string       m_tag = "R2";
   string       m_dtag = "R7";
   int          idx [NS];
   bit          f_desc = 0, f_beat = 0;
   logic [NS-1:0] f_src = '0;

   function automatic logic [31:0] lane_word(int i, int k);
      return (32'(k) * 32'h9E3779B1) ^ {8'(i + 1), 24'h5A3C96} ^ 32'(i * 7 + k);
   endfunction

   function automatic logic [31:0] mk(int op, int n, bit p, bit q, bit irq);
      logic [31:0] c = '0;
      c[31:28] = 4'(op);
      c[25:22] = 4'(n);
      c[17] = p;
      c[16] = q;
      c[27] = irq;
      c[5:0] = 6'h2B;   // unrelated bits, must have no effect
      return c;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_take(logic [31:0] c, logic [31:0] s);
      int op = int'(c[31:28]);
      int n  = int'(c[25:22]);
      longint wds = (longint'(s) + 3) / 4;
      m_irq = c[27];
      m_err = 0;
      m_mask = '0;
      if (op == 0) begin
         m_tag = "R2";
      end else if (op == 1) begin
         m_mask = 1;
         m_dtag = "R6";
         m_tag = "R8";
      end else if (op == 6) begin
         if (n < 1 || n > 8) begin
            m_err = 1; m_tag = "R4";
         end else if (!c[17]) begin
            m_err = 1; m_tag = "R5";
         end else begin
            for (int i = 0; i < n; i++) m_mask[i] = 1'b1;
            m_dtag = "R7";
            m_tag = c[16] ? "R5" : "R8";
         end
      end else begin
         m_err = 1; m_tag = "R3";
      end
      if (m_err) m_mask = '0;
      if (m_mask != 0 && wds == 0) m_tag = "R9";
      if (m_mask != 0 && wds != 0) begin
         m_st = 1; m_rem = wds;
      end else begin
         m_st = 2;
      end
   endtask

   always @(negedge clk) begin : stepper
      logic [31:0] exp_word;
      bit exp_dv, ok;
      logic [NS-1:0] exp_sr;
      // 1. advance the model by what happened at the last rising edge
      if (!rst_n) begin
         m_st = 0; m_mask = '0;
      end else begin
         for (int i = 0; i < NS; i++) if (f_src[i]) idx[i]++;
         case (m_st)
            0: if (f_desc) begin
               model_take(q_ctrl[0], q_size[0]);
               void'(q_ctrl.pop_front());
               void'(q_size.pop_front());
            end
            1: if (f_beat) begin
               m_rem--;
               if (m_rem == 0) m_st = 2;
            end
            default: m_st = 0;
         endcase
      end
      // 2. drive inputs for this cycle
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      desc_valid = rst_n && (q_ctrl.size() != 0);
      if (q_ctrl.size() != 0) begin
         desc_ctrl = q_ctrl[0];
         desc_size = q_size[0];
      end
      for (int i = 0; i < NS; i++) begin
         src_valid[i] = stall ? lfsr[i] | lfsr[i+5] : 1'b1;
         src_data[i*DW +: DW] = lane_word(i, idx[i]);
      end
      dst_ready = stall ? (lfsr[3] | lfsr[11]) : 1'b1;
      // 3. sample and compare
      #1;
      ok = 1;
      exp_word = '0;
      for (int i = 0; i < NS; i++) begin
         if (m_mask[i]) begin
            ok = ok && src_valid[i];
            exp_word = exp_word ^ lane_word(i, idx[i]);
         end
      end
      exp_dv = (m_st == 1) && ok;
      exp_sr = (exp_dv && dst_ready) ? m_mask : '0;
      if (!rst_n) begin
         chk("R1", "desc_ready", 32'(desc_ready), 32'd1);
         chk("R1", "dst_valid", 32'(dst_valid), 32'd0);
         chk("R1", "done_valid", 32'(done_valid), 32'd0);
         chk("R1", "src_ready", 32'(src_ready), 32'd0);
      end else begin
         chk("R10", "desc_ready", 32'(desc_ready), 32'(m_st == 0));
         chk(m_tag, "done_valid", 32'(done_valid), 32'(m_st == 2));
         if (m_st == 2) begin
            chk(m_tag, "done_err", 32'(done_err), 32'(m_err));
            chk(m_tag, "done_irq", 32'(done_irq), 32'(m_irq));
         end
         chk(m_st == 1 ? m_dtag : m_tag, "dst_valid", 32'(dst_valid), 32'(exp_dv));
         chk(m_st == 1 ? m_dtag : m_tag, "src_ready", 32'(src_ready), 32'(exp_sr));
         if (exp_dv) chk(m_dtag, "dst_data", dst_data, exp_word);
      end
      f_desc = rst_n && (m_st == 0) && desc_valid;
      f_beat = exp_dv && dst_ready;
      f_src  = exp_sr & src_valid;
   end

   task automatic push(logic [31:0] c, logic [31:0] s);
      q_ctrl.push_back(c);
      q_size.push_back(s);
   endtask

   task automatic load_batch();
      push(mk(0, 0, 0, 0, 1), 32'd64);     // R2 idle, interrupt requested
      push(mk(0, 3, 1, 0, 0), 32'd8);      // R2 idle, no interrupt
      push(mk(2, 2, 1, 0, 1), 32'd16);     // R3
      push(mk(5, 2, 1, 0, 0), 32'd16);     // R3
      push(mk(8, 1, 1, 0, 0), 32'd4);      // R3
      push(mk(15, 4, 1, 0, 1), 32'd4);     // R3
      push(mk(6, 0, 1, 0, 1), 32'd16);     // R4 zero lanes
      push(mk(6, 9, 1, 0, 0), 32'd16);     // R4 nine lanes
      push(mk(6, 15, 1, 0, 0), 32'd16);    // R4
      push(mk(6, 3, 0, 1, 1), 32'd16);     // R5 parity disabled
      push(mk(6, 3, 1, 1, 0), 32'd20);     // R5 Q flag ignored
      push(mk(1, 5, 0, 0, 1), 32'd16);     // R6 copy 4 words
      push(mk(1, 0, 0, 0, 0), 32'd13);     // R8 rounds up to 4
      push(mk(1, 0, 0, 0, 1), 32'd1);      // R8 one word
      push(mk(6, 1, 1, 0, 0), 32'd12);     // R7 single lane
      push(mk(6, 2, 1, 0, 1), 32'd7);      // R7 two lanes, 2 words
      push(mk(6, 3, 1, 0, 0), 32'd40);     // R7
      push(mk(6, 8, 1, 0, 1), 32'd400);    // R7 all lanes, 100 words
      push(mk(1, 0, 0, 0, 1), 32'd0);      // R9 copy zero length
      push(mk(6, 4, 1, 0, 0), 32'd0);      // R9 parity zero length
      push(mk(6, 5, 1, 0, 1), 32'd3);      // R8 partial word
   endtask

   task automatic drain();
      while (q_ctrl.size() != 0 || m_st != 0) @(posedge clk);
   endtask

   initial begin
      for (int i = 0; i < NS; i++) idx[i] = 0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      stall = 0;
      load_batch();
      drain();
      repeat (3) @(posedge clk);
      #2 stall = 1;
      load_batch();
      drain();
      repeat (5) @(posedge clk);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got %0d cycles expected under 100000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule